// File: doc/BRIEF.md
# Chained Two-Master Interrupt Aggregator

This block collects 112 interrupt lines, groups them into 14 blocks of 8, and presents them to software through a small register space with an 8-bit data path. The blocks are split between two masters of seven blocks each. Every block has its own fixed register window, so software reaches a block's latched pending bits, its clear register, its mask and the live line levels with one access each. It never writes a select register first.

Each master has a summary byte. Bits 1 to 7 show which of its blocks hold a pending, unmasked line. Bit 0 of master 0's summary is a chain flag: it is set when anything in master 1 is pending and unmasked. A handler reads master 0's summary first and only visits master 1 when that flag is set. One level-sensitive output, `irq_out`, is high while any unmasked pending bit exists.

The inputs are asynchronous and pass through a synchroniser. A rising edge latches the pending bit even when the line is masked. The mask only gates what reaches the summaries and the output. To acknowledge a line, software masks it, clears it, and then unmasks it.

The register port has no back-pressure. A read or a write is accepted in every cycle it is requested. Read data comes back exactly one cycle later with a valid strobe. The port cannot stall, so there is no ready signal.

Top module: `iagg_top`

## Requirements
- R1: After reset every mask bit reads 1, every pending bit and every summary reads 0, and `irq_out` is 0.
- R2: The address is {master (bit 5), local block (bits 4:2), register (bits 1:0)}. Local blocks 1 to 7 decode the register field as 0 = pending, 1 = clear, 2 = mask and 3 = raw. Local block 0 with register 0 is the master summary, and the other registers of local block 0 read 0. Input index = ((master*7 + local block - 1)*8 + bit).
- R3: A read request places its data on `bus_rdata` with `bus_rvalid` high in the following cycle. `bus_rvalid` is low in a cycle that follows no read request.
- R4: The raw register shows the synchronised line levels, whatever the mask holds.
- R5: A rising edge of a synchronised line sets its pending bit, whether the line is masked or not. A line that stays high does not set the bit again after it has been cleared.
- R6: Writing the mask register stores the byte. Bit n = 1 masks line n, and the mask reads back as written.
- R7: Writing 1 to bit n of the clear register clears pending bit n. Bits written as 0 leave their pending bits unchanged. The clear register reads 0.
- R8: Summary bit b (1 to 7) of a master is 1 exactly when local block b holds a pending bit whose mask bit is 0.
- R9: Summary bit 0 of master 0 is 1 exactly when some block of master 1 holds an unmasked pending bit. Summary bit 0 of master 1 reads 0.
- R10: `irq_out` is 1 exactly when some unmasked pending bit exists anywhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 112 | Asynchronous interrupt lines |
| bus_addr | input | 6 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq_out | output | 1 | Summary interrupt, level |

## Verification
The bench latches a line while it is masked and checks that neither the summary nor `irq_out` reacts. A design that gated the latch with the mask would lose the event entirely. It writes a clear byte with zeros around the pending bit: a design that treated the byte as a value rather than as write-one strobes would wipe or keep the wrong bits. It clears a line that is still held high and checks that the bit does not come back, which catches level latching. Lines in master 1, including the last one at index 111, must surface both in master 1's summary and as the chain bit of master 0. A wrong block offset or a missing chain would leave the handler blind to them.

// File: rtl/iagg_pkg.sv
package iagg_pkg;
  localparam int LINES     = 8;
  localparam int BLK_PER_M = 7;
  localparam int MASTERS   = 2;
  localparam int NBLK      = MASTERS * BLK_PER_M;
  localparam int NUM_IRQ   = NBLK * LINES;
  localparam int REG_W     = 2;
  localparam int BLK_W     = $clog2(BLK_PER_M + 1);
  localparam int MST_W     = (MASTERS > 1) ? $clog2(MASTERS) : 1;
  localparam int ADDR_W    = MST_W + BLK_W + REG_W;

  typedef enum logic [REG_W-1:0] {
    REG_PEND = 2'd0,
    REG_CLR  = 2'd1,
    REG_MASK = 2'd2,
    REG_RAW  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/iagg_sync.sv
module iagg_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/iagg_block.sv
module iagg_block #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_s,
  input  logic         wr_clr,
  input  logic         wr_mask,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend,
  output logic [W-1:0] mask,
  output logic [W-1:0] raw,
  output logic         active
);
  logic [W-1:0] prev;
  logic [W-1:0] rise;
  logic [W-1:0] clr_bits;

  assign rise     = line_s & ~prev;
  assign clr_bits = wr_clr ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      pend <= '0;
      mask <= '1;
    end else begin
      prev <= line_s;
      // a new edge in the same cycle as its clear keeps the bit set
      pend <= (pend & ~clr_bits) | rise;
      if (wr_mask) mask <= wdata;
    end
  end

  assign raw    = line_s;
  assign active = |(pend & ~mask);
endmodule

// File: rtl/iagg_top.sv
module iagg_top
  import iagg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [LINES-1:0]   bus_wdata,
  output logic [LINES-1:0]   bus_rdata,
  output logic               bus_rvalid,
  output logic               irq_out
);
  logic [NUM_IRQ-1:0] line_s;
  logic [NUM_IRQ-1:0] pend_all;
  logic [NUM_IRQ-1:0] mask_all;
  logic [LINES-1:0]   pend_a [NBLK];
  logic [LINES-1:0]   mask_a [NBLK];
  logic [LINES-1:0]   raw_a  [NBLK];
  logic [NBLK-1:0]    act;
  logic [LINES-1:0]   sum_a  [MASTERS];
  logic [MST_W-1:0]   a_m;
  logic [BLK_W-1:0]   a_b;
  logic [REG_W-1:0]   a_r;
  logic [LINES-1:0]   rd_mux;

  assign {a_m, a_b, a_r} = bus_addr;

  iagg_sync #(.W(NUM_IRQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_in), .q(line_s)
  );

  for (genvar m = 0; m < MASTERS; m++) begin : g_mst
    for (genvar b = 0; b < BLK_PER_M; b++) begin : g_blk
      localparam int IDX = m * BLK_PER_M + b;
      logic hit;
      assign hit = bus_wr && (a_m == MST_W'(m)) && (a_b == BLK_W'(b + 1));
      iagg_block #(.W(LINES)) u_blk (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_s (line_s[IDX*LINES +: LINES]),
        .wr_clr (hit && (a_r == REG_CLR)),
        .wr_mask(hit && (a_r == REG_MASK)),
        .wdata  (bus_wdata),
        .pend   (pend_a[IDX]),
        .mask   (mask_a[IDX]),
        .raw    (raw_a[IDX]),
        .active (act[IDX])
      );
      assign pend_all[IDX*LINES +: LINES] = pend_a[IDX];
      assign mask_all[IDX*LINES +: LINES] = mask_a[IDX];
    end
    // chain bit: activity in any later master
    if (m < MASTERS - 1) begin : g_chain
      assign sum_a[m] = {act[m*BLK_PER_M +: BLK_PER_M],
                         |act[NBLK-1:(m+1)*BLK_PER_M]};
    end else begin : g_last
      assign sum_a[m] = {act[m*BLK_PER_M +: BLK_PER_M], 1'b0};
    end
  end

  always_comb begin
    int idx;
    rd_mux = '0;
    idx    = int'(a_m) * BLK_PER_M + int'(a_b) - 1;
    if (a_b == '0) begin
      if (a_r == REG_PEND) rd_mux = sum_a[a_m];
    end else begin
      case (a_r)
        REG_PEND: rd_mux = pend_a[idx];
        REG_MASK: rd_mux = mask_a[idx];
        REG_RAW:  rd_mux = raw_a[idx];
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  assign irq_out = |sum_a[0];
endmodule

// File: rtl/iagg_chk.sv
module iagg_chk
  import iagg_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic               bus_rvalid,
  input logic               irq_out,
  input logic [NUM_IRQ-1:0] pend_vec,
  input logic [NUM_IRQ-1:0] mask_vec
);
  p_rvalid_follows_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  p_no_stray_rvalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  p_mask_moves_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mask_vec) |-> $past(bus_wr && bus_addr[1:0] == 2'(REG_MASK)));

  p_pend_drop_on_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(pend_vec) & ~pend_vec)) |-> $past(bus_wr && bus_addr[1:0] == 2'(REG_CLR)));

  p_irq_matches_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (|(pend_vec & ~mask_vec)));
endmodule

bind iagg_top iagg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rvalid(bus_rvalid),
  .irq_out   (irq_out),
  .pend_vec  (pend_all),
  .mask_vec  (mask_all)
);

// File: tb/test_iagg_top.sv
module test_iagg_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [111:0] irq_in = '0;
  logic [5:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [7:0]   bus_wdata = '0;
  logic [7:0]   bus_rdata;
  logic         bus_rvalid;
  logic         irq_out;

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;

  iagg_top i_iagg_top (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq_out(irq_out)
  );

  function automatic logic [5:0] ad(int m, int b, int r);
    return 6'(m * 32 + b * 4 + r);
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compare each returned read with the queued value
  always @(negedge clk) begin
    if (rst_n && bus_rvalid && !finished) begin
      if (exp_q.size() == 0) begin
        checks++; errs++;
        $display("FAIL R3 unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic rd(logic [5:0] a, logic [7:0] e, string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq_out after reset", {7'd0, irq_out}, 8'h00);
    rd(ad(0,0,0), 8'h00, "R1 summary m0 after reset");
    rd(ad(0,1,2), 8'hFF, "R1 mask m0b1 after reset");
    rd(ad(1,7,0), 8'h00, "R1 pending m1b7 after reset");
    rd(ad(0,0,1), 8'h00, "R2 unused address in block 0");
    @(negedge clk);
    check("R3 rvalid low when idle", {7'd0, bus_rvalid}, 8'h00);

    // line 21 = master0 block3 bit5, masked
    irq_in[21] = 1'b1; settle();
    rd(ad(0,3,3), 8'h20, "R4 raw shows masked line");
    rd(ad(0,3,0), 8'h20, "R5 masked line still latches");
    rd(ad(0,0,0), 8'h00, "R8 masked pending not in summary");
    check("R10 irq low while masked", {7'd0, irq_out}, 8'h00);

    wr(ad(0,3,2), 8'hDF); settle();
    rd(ad(0,3,2), 8'hDF, "R6 mask readback");
    rd(ad(0,0,0), 8'h08, "R8 summary bit3 after unmask");
    check("R10 irq high when unmasked", {7'd0, irq_out}, 8'h01);

    wr(ad(0,3,1), 8'hDF); settle();
    rd(ad(0,3,0), 8'h20, "R7 zero bits of clear ignored");
    rd(ad(0,3,1), 8'h00, "R7 clear register reads zero");

    // acknowledge: mask, clear, unmask while line is still high
    wr(ad(0,3,2), 8'hFF); settle();
    check("R6 mask removes irq", {7'd0, irq_out}, 8'h00);
    wr(ad(0,3,1), 8'h20); settle();
    rd(ad(0,3,0), 8'h00, "R7 clear one bit");
    wr(ad(0,3,2), 8'hDF); settle();
    rd(ad(0,3,0), 8'h00, "R5 held level does not relatch");
    check("R10 irq low after ack", {7'd0, irq_out}, 8'h00);

    irq_in[21] = 1'b0; settle();
    irq_in[21] = 1'b1; settle();
    rd(ad(0,3,0), 8'h20, "R5 new edge latches");
    check("R10 irq after new edge", {7'd0, irq_out}, 8'h01);
    wr(ad(0,3,1), 8'h20); settle();

    // line 58 = master1 block1 bit2
    irq_in[58] = 1'b1; settle();
    rd(ad(0,0,0), 8'h00, "R9 masked master1 line no chain");
    wr(ad(1,1,2), 8'hFB); settle();
    rd(ad(1,0,0), 8'h02, "R8 master1 summary bit1");
    rd(ad(0,0,0), 8'h01, "R9 chain bit in master0");
    rd(ad(1,1,0), 8'h04, "R2 line 58 maps to m1b1 bit2");
    check("R10 irq from master1", {7'd0, irq_out}, 8'h01);

    // line 111 = master1 block7 bit7
    wr(ad(1,7,2), 8'h7F);
    irq_in[111] = 1'b1; settle();
    rd(ad(1,0,0), 8'h82, "R2 line 111 maps to m1b7");
    wr(ad(1,1,1), 8'hFF);
    wr(ad(1,7,1), 8'h80); settle();
    rd(ad(1,0,0), 8'h00, "R9 master1 summary cleared");
    rd(ad(0,0,0), 8'h00, "R9 chain bit cleared");
    check("R10 irq low at end", {7'd0, irq_out}, 8'h00);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errs++;
      $display("FAIL R3 reads unanswered actual=%0d expected=0", exp_q.size());
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errs++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule